// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit

This unit does the two long arithmetic operations of a small two-register accumulator machine. The machine's two working registers, R0 and R1, feed the operand inputs. A one-cycle start pulse and an operation select begin an unsigned multiply or an unsigned divide. The unit captures both operands when it accepts the start and ignores its operand inputs after that. Multiply uses shift-and-add and divide uses restoring division. Each retires one bit per cycle for eight cycles. A divide by zero skips the iterations and answers with a fixed pattern on the next cycle.

The answer comes back as two bytes: one for R0 and one for R1. A multiply returns the product with its high byte on the R0 port and its low byte on the R1 port. A divide returns the quotient on the R0 port and the remainder on the R1 port. A divide also writes the carry flag. A multiply leaves the carry flag alone.

The sequencer holds the machine while `busy_o` is high and takes the answer in the single cycle that `done_o` is high. The result side has no ready input and cannot be back-pressured. The unit holds no result for a late consumer, so the sequencer must latch the answer in that same cycle. The unit accepts a new start only while `busy_o` is low, and that includes the cycle in which `done_o` is high.

Top module: `mdu_core`

## Requirements
- R1: With `op_div_i` = 0 (multiply), the unsigned 16-bit product `opa_i*opb_i` appears with bits 15:8 on `res_r0_o` and bits 7:0 on `res_r1_o` in the `done_o` cycle.
- R2: A multiply holds `carry_we_o` low in its `done_o` cycle, so the carry flag keeps its value.
- R3: With `op_div_i` = 1 and a non-zero divisor, the unsigned quotient `opa_i/opb_i` appears on `res_r0_o` and the remainder on `res_r1_o` in the `done_o` cycle.
- R4: A divide with a non-zero divisor drives `carry_we_o` = 1 and `carry_o` = 0 in its `done_o` cycle.
- R5: A divide whose `opb_i` is zero at the accepted start gives `done_o` in the very next cycle, with `res_r0_o` = 0xFF, `res_r1_o` = 0x00, `carry_we_o` = 1, `carry_o` = 1, and `busy_o` never raised.
- R6: For any other operation, `busy_o` is high for exactly 8 cycles, starting in the cycle after the start is sampled. `done_o` is high in the cycle right after `busy_o` falls.
- R7: `done_o` lasts exactly one cycle and is never high together with `busy_o`.
- R8: A start pulse that arrives while `busy_o` is high is ignored. The running operation finishes with its own results, latency and operation type.
- R9: While reset (`rst_n`, active low) is held, `busy_o` and `done_o` are both low.
- R10: The operation uses only the operands present at the accepted start. Changes to `opa_i`, `opb_i` or `op_div_i` afterwards do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled at a rising edge while not busy |
| op_div_i | input | 1 | Operation select: 0 multiply, 1 divide |
| opa_i | input | 8 | Operand from R0 (multiplier or dividend) |
| opb_i | input | 8 | Operand from R1 (multiplicand or divisor) |
| busy_o | output | 1 | Iterations in progress |
| done_o | output | 1 | One-cycle result strobe |
| res_r0_o | output | 8 | Result for R0: product high byte or quotient |
| res_r1_o | output | 8 | Result for R1: product low byte or remainder |
| carry_we_o | output | 1 | Carry flag write enable, valid with `done_o` |
| carry_o | output | 1 | New carry value, valid with `carry_we_o` |

## Verification
The checker assumes that the operand inputs seen at an accepted start are the ones the result must reflect. It also assumes that `start_i` is a clean synchronous level, so that acceptance is exactly `start_i` high with `busy_o` low. The product and quotient checks rest on operands that the checker captures only under that condition. The bench drives every input on the falling edge. It raises starts while the unit is busy and scrambles the operands after acceptance. Neither of those reaches a capture, so the checker and the bench still agree on which operation is in flight.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic {
    OP_MUL = 1'b0,
    OP_DIV = 1'b1
  } mdu_op_e;
endpackage

// File: rtl/mdu_mul_step.sv
// One shift-and-add iteration: {acc, mlt} holds the partial product,
// mlt's low bit decides whether the multiplicand joins the accumulator.
module mdu_mul_step #(
  parameter int W = 8
) (
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] mlt_i,
  input  logic [W-1:0] mcand_i,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] mlt_o
);
  logic [W:0] sum;

  always_comb begin
    sum = mlt_i[0] ? ({1'b0, acc_i} + {1'b0, mcand_i}) : {1'b0, acc_i};
    {acc_o, mlt_o} = {sum, mlt_i[W-1:1]};
  end
endmodule

// File: rtl/mdu_div_step.sv
// One restoring-division iteration: bring in the next dividend bit,
// subtract the divisor only when it fits, shift the outcome into the quotient.
module mdu_div_step #(
  parameter int W = 8
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o
);
  logic [W:0]   shifted;
  logic         fits;
  logic [W-1:0] diff;

  always_comb begin
    shifted = {rem_i, quo_i[W-1]};
    fits    = shifted >= {1'b0, dvs_i};
    // result is below the divisor, so the low W bits are exact
    diff    = shifted[W-1:0] - dvs_i;
    rem_o   = fits ? diff : shifted[W-1:0];
    quo_o   = {quo_i[W-2:0], fits};
  end
endmodule

// File: rtl/mdu_seq.sv
// Iteration sequencer: counts W busy cycles, then strobes done.
// A zero-divisor start strobes done at once without going busy.
module mdu_seq #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept_i,
  input  logic short_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_o <= 1'b0;
      if (busy_o) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end else if (accept_i) begin
        cnt_q <= '0;
        if (short_i) done_o <= 1'b1;
        else         busy_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdu_core.sv
module mdu_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         op_div_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] res_r0_o,
  output logic [W-1:0] res_r1_o,
  output logic         carry_we_o,
  output logic         carry_o
);
  import mdu_pkg::*;

  // hi_q: multiply accumulator / divide remainder
  // lo_q: multiplier being consumed / quotient being built
  logic [W-1:0] hi_q, lo_q, opnd_q;
  mdu_op_e      op_q;
  logic         dz_q;
  logic         accept, div_zero;
  logic [W-1:0] mul_hi, mul_lo, div_hi, div_lo;

  assign accept   = start_i && !busy_o;
  assign div_zero = op_div_i && (opb_i == '0);

  mdu_seq #(.W(W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (accept),
    .short_i  (div_zero),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  mdu_mul_step #(.W(W)) u_mul (
    .acc_i   (hi_q),
    .mlt_i   (lo_q),
    .mcand_i (opnd_q),
    .acc_o   (mul_hi),
    .mlt_o   (mul_lo)
  );

  mdu_div_step #(.W(W)) u_div (
    .rem_i (hi_q),
    .quo_i (lo_q),
    .dvs_i (opnd_q),
    .rem_o (div_hi),
    .quo_o (div_lo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      opnd_q <= '0;
      op_q   <= OP_MUL;
      dz_q   <= 1'b0;
    end else if (busy_o) begin
      if (op_q == OP_DIV) begin
        hi_q <= div_hi;
        lo_q <= div_lo;
      end else begin
        hi_q <= mul_hi;
        lo_q <= mul_lo;
      end
    end else if (accept) begin
      op_q   <= op_div_i ? OP_DIV : OP_MUL;
      opnd_q <= opb_i;
      dz_q   <= div_zero;
      hi_q   <= '0;
      lo_q   <= div_zero ? '1 : opa_i;
    end
  end

  // divide keeps quotient in lo_q and remainder in hi_q
  assign res_r0_o   = (op_q == OP_DIV) ? lo_q : hi_q;
  assign res_r1_o   = (op_q == OP_DIV) ? hi_q : lo_q;
  assign carry_we_o = done_o && (op_q == OP_DIV);
  assign carry_o    = dz_q;
endmodule

// File: rtl/mdu_core_chk.sv
module mdu_core_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic         op_div_i,
  input logic [W-1:0] opa_i,
  input logic [W-1:0] opb_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] res_r0_o,
  input logic [W-1:0] res_r1_o,
  input logic         carry_we_o,
  input logic         carry_o
);
  localparam int BW = $clog2(W + 1) + 1;

  logic [W-1:0]   cap_a, cap_b;
  logic           cap_div;
  logic [BW-1:0]  blen;
  logic [2*W-1:0] prod;
  logic [W-1:0]   quo, rem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_a   <= '0;
      cap_b   <= '0;
      cap_div <= 1'b0;
      blen    <= '0;
    end else begin
      if (start_i && !busy_o) begin
        cap_a   <= opa_i;
        cap_b   <= opb_i;
        cap_div <= op_div_i;
      end
      blen <= busy_o ? blen + 1'b1 : '0;
    end
  end

  always_comb begin
    prod = {{W{1'b0}}, cap_a} * {{W{1'b0}}, cap_b};
    quo  = (cap_b != '0) ? cap_a / cap_b : '0;
    rem  = (cap_b != '0) ? cap_a % cap_b : '0;
  end

  a_r1_product: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !cap_div) |-> ({res_r0_o, res_r1_o} == prod));

  a_r2_mul_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !cap_div) |-> !carry_we_o);

  a_r3_quotient: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && cap_div && cap_b != '0) |-> (res_r0_o == quo && res_r1_o == rem));

  a_r4_div_clears_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && cap_div && cap_b != '0) |-> (carry_we_o && !carry_o));

  a_r5_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && op_div_i && opb_i == '0) |=>
      (done_o && !busy_o && res_r0_o == '1 && res_r1_o == '0 && carry_we_o && carry_o));

  a_r6_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (done_o && blen == BW'(W)));

  a_r6_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (blen < BW'(W)));

  a_r7_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !done_o);
endmodule

bind mdu_core mdu_core_chk #(.W(W)) u_mdu_core_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .op_div_i   (op_div_i),
  .opa_i      (opa_i),
  .opb_i      (opb_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .res_r0_o   (res_r0_o),
  .res_r1_o   (res_r1_o),
  .carry_we_o (carry_we_o),
  .carry_o    (carry_o)
);

// File: tb/test_mdu_core.sv
module test_mdu_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       op_div_i = 1'b0;
  logic [7:0] opa_i = '0;
  logic [7:0] opb_i = '0;
  logic       busy_o, done_o, carry_we_o, carry_o;
  logic [7:0] res_r0_o, res_r1_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  mdu_core #(.W(8)) i_mdu_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .op_div_i   (op_div_i),
    .opa_i      (opa_i),
    .opb_i      (opb_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .res_r0_o   (res_r0_o),
    .res_r1_o   (res_r1_o),
    .carry_we_o (carry_we_o),
    .carry_o    (carry_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Runs one operation and checks every output against values derived
  // from the requirements. disturb raises start while busy (R8).
  task automatic run_op(input logic [7:0] a, input logic [7:0] b,
                        input bit div, input bit disturb);
    logic [15:0] p;
    logic [7:0]  e0, e1;
    bit          ewe, ec;
    int          elat, n, busy_seen;
    if (div && b == 0) begin
      e0 = 8'hFF; e1 = 8'h00; ewe = 1; ec = 1; elat = 1;      // R5
    end else if (div) begin
      e0 = a / b; e1 = a % b; ewe = 1; ec = 0; elat = 9;     // R3, R4
    end else begin
      p = 16'(a) * 16'(b);
      e0 = p[15:8]; e1 = p[7:0]; ewe = 0; ec = 0; elat = 9;  // R1, R2
    end
    @(negedge clk);
    start_i = 1'b1; opa_i = a; opb_i = b; op_div_i = div;
    @(negedge clk);
    start_i = 1'b0;
    opa_i = ~a; opb_i = b ^ 8'h5A; op_div_i = ~div;           // R10 scramble
    n = 1; busy_seen = 0;
    while (!done_o && n < 20) begin
      if (busy_o) busy_seen++;
      start_i = (disturb && n == 3);                           // R8 late start
      if (disturb && n == 3) opb_i = 8'h00;
      @(negedge clk);
      n++;
    end
    start_i = 1'b0;
    check(n == elat, "R6 latency", n, elat);
    check(busy_seen == elat - 1, "R6 busy cycles", busy_seen, elat - 1);
    check(res_r0_o == e0, div ? "R3/R10 r0 result" : "R1/R10 r0 result", res_r0_o, e0);
    check(res_r1_o == e1, div ? "R3/R10 r1 result" : "R1/R10 r1 result", res_r1_o, e1);
    check(carry_we_o == ewe, div ? "R4 carry write" : "R2 carry write", carry_we_o, ewe);
    if (ewe) check(carry_o == ec, (b == 0) ? "R5 carry value" : "R4 carry value", carry_o, ec);
    check(!busy_o, "R7 busy with done", busy_o, 0);
    @(negedge clk);
    check(!done_o, "R7 done width", done_o, 0);
    if (disturb) check(!busy_o, "R8 late start ignored", busy_o, 0);
  endtask

  task automatic test_reset();
    @(negedge clk);
    check(!busy_o, "R9 busy in reset", busy_o, 0);
    check(!done_o, "R9 done in reset", done_o, 0);
    start_i = 1'b1;
    @(negedge clk);
    check(!busy_o && !done_o, "R9 start during reset", {busy_o, done_o}, 0);
    start_i = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic test_multiply();
    run_op(8'd13, 8'd11, 1'b0, 1'b0);
    run_op(8'hFF, 8'hFF, 1'b0, 1'b0);
    run_op(8'h00, 8'h9C, 1'b0, 1'b0);
    run_op(8'h80, 8'h02, 1'b0, 1'b0);
  endtask

  task automatic test_divide();
    run_op(8'd200, 8'd7, 1'b1, 1'b0);
    run_op(8'd5, 8'd9, 1'b1, 1'b0);
    run_op(8'hFF, 8'h01, 1'b1, 1'b0);
    run_op(8'hFF, 8'hFF, 1'b1, 1'b0);
  endtask

  task automatic test_div_zero();
    run_op(8'd77, 8'd0, 1'b1, 1'b0);
    run_op(8'd0, 8'd0, 1'b1, 1'b0);
  endtask

  task automatic test_busy_start();
    run_op(8'd57, 8'd3, 1'b0, 1'b1);
    run_op(8'd250, 8'd16, 1'b1, 1'b1);
  endtask

  task automatic test_sweep();
    for (int i = 1; i < 9; i++) begin
      run_op(8'(i * 29), 8'(i * 13 + 1), 1'b0, 1'b0);
      run_op(8'(i * 31), 8'(i * 3), 1'b1, 1'b0);
    end
  endtask

  initial begin
    test_reset();
    test_multiply();
    test_divide();
    test_div_zero();
    test_busy_start();
    test_sweep();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule